// File: doc/BRIEF.md
# Autocalibration Sequencer with Correction Store

This block is the digital side of a self-calibrating, binary-weighted capacitor-array converter. When calibration is requested, it clears all of its state, aborts whatever it was doing and holds `busy` high. Once the request is released it runs a fixed routine. The routine has ten measurement steps. Step 0 measures the hold-circuit offset with the input tied to ground sense. Steps 1 to 9 measure the mismatch of the MSB weight and then of each of the next eight weights in descending order. Every step's result goes into a ten-entry correction store. The analog charge transfer, comparator and calibration DAC stay outside the block. It reaches them through a simple request/response measurement port.

The routine always lasts exactly `CAL_CYCLES` clocks, 85,530 by default. Idle padding fills the time left over after the ten steps. After `busy` falls, one more clock is spent finishing calibration. A conversion word offered in that clock has its result delayed by one cycle.

Once calibration is complete, each raw conversion word presented to the block comes back corrected. The correction is the offset entry plus every weight entry whose matching high-order result bit is set. It is subtracted from the raw word, and the difference is clamped to the unsigned output range.

Top module: `autocal_seq`

## Requirements
- R1: Raising `cal_req` clears all state asynchronously, with no clock needed. `busy` is 1, `meas_start` is 0, `res_valid` is 0 and `res_data` is 0. A calibration in progress is abandoned.
- R2: While `rst_n` is low at a clock edge, the same cleared state results. The routine starts as soon as `rst_n` is high and `cal_req` is low, and step 0 is requested at once (`meas_start`=1, `meas_sel`=0).
- R3: Count clock edges starting with the first edge after `cal_req` is released. `busy` stays 1 through edge 85,529 and is 0 after edge 85,530. It stays 0 until the next request.
- R4: Ten step requests occur, each a single-cycle `meas_start` pulse. `meas_sel` takes the values 0 (offset), then 1 to 9 (MSB down to MSB-8). Consecutive requests are exactly `MEAS_WAIT`+1 cycles apart, and no request follows step 9.
- R5: The response window is the `MEAS_WAIT` clock edges that follow a step's request cycle. Only a `meas_valid` seen within that window counts, and the first one in the window is kept. A step with no response in its window takes the value 0.
- R6: Entry 0 holds the measured offset. Entry k (k = 1..9) holds its measured value minus entry 0, saturated to the signed 16-bit range.
- R7: After calibration, `conv_valid` with `conv_raw` produces a single-cycle `res_valid` on the next cycle. `res_data` = clamp(`conv_raw` − (entry 0 + Σ entry k for each k with `conv_raw` bit 16−k set)) to 0..65535. So bit 15 selects entry 1 and bit 7 selects entry 9.
- R8: A `conv_valid` while `busy` is 1 is ignored: no `res_valid` follows and `res_data` does not change.
- R9: A `conv_valid` in the first cycle after `busy` falls has its `res_valid` two cycles later instead of one.
- R10: `res_data` holds its value between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_req | input | 1 | Calibration request; asynchronous clear while high |
| busy | output | 1 | High from the request until the routine completes |
| meas_start | output | 1 | One-cycle request for the measurement selected by meas_sel |
| meas_sel | output | 4 | Step index: 0 offset, 1..9 weight MSB..MSB-8 |
| meas_valid | input | 1 | Measurement response strobe |
| meas_value | input | 16 | Signed measured value |
| conv_valid | input | 1 | Raw conversion word present |
| conv_raw | input | 16 | Raw conversion word |
| res_valid | output | 1 | Corrected result strobe |
| res_data | output | 16 | Corrected result, held between strobes |

## Verification
Each step request is visible in the same cycle the step begins. A response driven at a falling edge is sampled by the next rising edge, so the bench places responses at offsets 1 to `MEAS_WAIT` inside the window and one cycle past it. `busy` is sampled at the falling edges after rising edges 85,529 and 85,530, counted from release. An ordinary corrected result is checked one falling edge after the word is applied. A word offered in the finishing cycle is checked at one and at two falling edges. Because the stored entries are visible only through corrected results, the vectors pick raw words that isolate single weights, combinations and both clamp limits.

// File: rtl/acal_pkg.sv
// Shared types and helpers for the autocalibration sequencer.
// Assumes two's-complement correction words of ACAL_DW bits.
package acal_pkg;
    localparam int ACAL_DW = 16;

    typedef logic signed [ACAL_DW-1:0] corr_t;

    // Saturating signed difference a - b, clamped to the corr_t range.
    function automatic corr_t sat_sub(input corr_t a, input corr_t b);
        logic signed [ACAL_DW:0] d;
        d = {a[ACAL_DW-1], a} - {b[ACAL_DW-1], b};
        if (d[ACAL_DW] != d[ACAL_DW-1])
            return d[ACAL_DW] ? {1'b1, {(ACAL_DW-1){1'b0}}} : {1'b0, {(ACAL_DW-1){1'b1}}};
        return d[ACAL_DW-1:0];
    endfunction
endpackage

// File: rtl/acal_step_seq.sv
// Calibration step sequencer. Counts the whole routine from request
// release to busy falling, issues one measurement request per step,
// collects the first response in each step's window and produces one
// store write per step. Assumes CAL_CYCLES > N_ENTRIES*(MEAS_WAIT+1).
module acal_step_seq
    import acal_pkg::*;
#(
    parameter int N_ENTRIES  = 10,
    parameter int MEAS_WAIT  = 32,
    parameter int CAL_CYCLES = 85530
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cal_req,
    input  logic                         meas_valid,
    input  corr_t                        meas_value,
    input  corr_t                        offset_entry,
    output logic                         busy,
    output logic                         fin,
    output logic                         meas_start,
    output logic [$clog2(N_ENTRIES)-1:0] meas_sel,
    output logic                         wr_en,
    output logic [$clog2(N_ENTRIES)-1:0] wr_idx,
    output corr_t                        wr_data
);
    localparam int IDX_W     = $clog2(N_ENTRIES);
    localparam int PH_W      = $clog2(MEAS_WAIT + 1);
    localparam int CNT_W     = $clog2(CAL_CYCLES + 1);
    localparam int LAST_STEP = N_ENTRIES - 1;

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             fin_q;
    logic [IDX_W-1:0] step_q;
    logic [PH_W-1:0]  phase_q;
    logic             done_q;
    logic             got_q;
    corr_t            cap_q;
    logic             run;
    corr_t            measured;

    // Total-length counter: busy drops on the CAL_CYCLES-th edge, then one finishing cycle.
    always_ff @(posedge clk or posedge cal_req) begin
        if (cal_req) begin
            cnt_q  <= '0;
            busy_q <= 1'b1;
            fin_q  <= 1'b0;
        end else if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b1;
            fin_q  <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(CAL_CYCLES - 1)) begin
                busy_q <= 1'b0;
                fin_q  <= 1'b1;
            end
        end else begin
            fin_q <= 1'b0;
        end
    end

    // Step and phase walk, with first-response capture inside each window.
    always_ff @(posedge clk or posedge cal_req) begin
        if (cal_req) begin
            step_q  <= '0;
            phase_q <= '0;
            done_q  <= 1'b0;
            got_q   <= 1'b0;
            cap_q   <= '0;
        end else if (!rst_n) begin
            step_q  <= '0;
            phase_q <= '0;
            done_q  <= 1'b0;
            got_q   <= 1'b0;
            cap_q   <= '0;
        end else if (busy_q && !done_q) begin
            if (phase_q == PH_W'(MEAS_WAIT)) begin
                phase_q <= '0;
                got_q   <= 1'b0;
                cap_q   <= '0;
                if (step_q == IDX_W'(LAST_STEP))
                    done_q <= 1'b1;
                else
                    step_q <= step_q + 1'b1;
            end else begin
                phase_q <= phase_q + 1'b1;
                if (phase_q != '0 && meas_valid && !got_q) begin
                    got_q <= 1'b1;
                    cap_q <= meas_value;
                end
            end
        end
    end

    // Request, write strobe and derived correction for the current step.
    always_comb begin
        run        = busy_q & rst_n & ~cal_req;
        meas_start = run & ~done_q & (phase_q == '0);
        wr_en      = run & ~done_q & (phase_q == PH_W'(MEAS_WAIT));
        measured   = got_q ? cap_q : (meas_valid ? meas_value : '0);
        wr_data    = (step_q == '0) ? measured : sat_sub(measured, offset_entry);
    end

    assign meas_sel = step_q;
    assign wr_idx   = step_q;
    assign busy     = busy_q;
    assign fin      = fin_q;
endmodule

// File: rtl/acal_corr_ram.sv
// Correction store: N_ENTRIES signed words written by the sequencer.
// All entries are readable in parallel for the conversion lookup.
// Cleared by a calibration request or by reset.
module acal_corr_ram
    import acal_pkg::*;
#(
    parameter int N_ENTRIES = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cal_req,
    input  logic                         wr_en,
    input  logic [$clog2(N_ENTRIES)-1:0] wr_idx,
    input  corr_t                        wr_data,
    output corr_t                        entries [N_ENTRIES]
);
    localparam int IDX_W = $clog2(N_ENTRIES);

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
        corr_t word_q;

        // One stored correction word, written when its index is selected.
        always_ff @(posedge clk or posedge cal_req) begin
            if (cal_req)
                word_q <= '0;
            else if (!rst_n)
                word_q <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))
                word_q <= wr_data;
        end

        assign entries[i] = word_q;
    end
endmodule

// File: rtl/acal_corr_apply.sv
// Conversion correction. Subtracts the offset entry, plus each weight
// entry whose high-order raw bit is set, from the raw word. Clamps the
// difference to the unsigned range and registers it. A word offered in
// the finishing cycle is parked and served one cycle later.
// Assumes N_ENTRIES-1 <= ACAL_DW.
module acal_corr_apply
    import acal_pkg::*;
#(
    parameter int N_ENTRIES = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cal_req,
    input  logic               busy,
    input  logic               fin,
    input  logic               conv_valid,
    input  logic [ACAL_DW-1:0] conv_raw,
    input  corr_t              entries [N_ENTRIES],
    output logic               res_valid,
    output logic [ACAL_DW-1:0] res_data
);
    localparam int DW    = ACAL_DW;
    localparam int SUM_W = DW + $clog2(N_ENTRIES) + 1;
    localparam int DIF_W = SUM_W + 1;

    logic                    pend_q;
    logic [DW-1:0]           pend_raw_q;
    logic                    ready;
    logic [DW-1:0]           op_raw;
    logic signed [SUM_W-1:0] term [N_ENTRIES];
    logic signed [SUM_W-1:0] sum;
    logic signed [DIF_W-1:0] diff;
    logic [DW-1:0]           clamped;

    assign ready  = ~busy & ~fin;
    assign op_raw = pend_q ? pend_raw_q : conv_raw;

    for (genvar k = 0; k < N_ENTRIES; k++) begin : g_term
        if (k == 0) begin : g_off
            assign term[k] = {{(SUM_W-DW){entries[k][DW-1]}}, entries[k]};
        end else begin : g_bit
            assign term[k] = op_raw[DW-k] ? {{(SUM_W-DW){entries[k][DW-1]}}, entries[k]} : '0;
        end
    end

    // Accumulate the selected correction terms.
    always_comb begin
        sum = '0;
        for (int k = 0; k < N_ENTRIES; k++)
            sum = sum + term[k];
    end

    // Subtract and clamp into 0 .. 2**DW-1.
    always_comb begin
        diff = $signed({{(DIF_W-DW){1'b0}}, op_raw}) - {sum[SUM_W-1], sum};
        if (diff[DIF_W-1])
            clamped = '0;
        else if (|diff[DIF_W-2:DW])
            clamped = '1;
        else
            clamped = diff[DW-1:0];
    end

    // Result register plus the parking slot for the finishing cycle.
    always_ff @(posedge clk or posedge cal_req) begin
        if (cal_req) begin
            pend_q     <= 1'b0;
            pend_raw_q <= '0;
            res_valid  <= 1'b0;
            res_data   <= '0;
        end else if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_raw_q <= '0;
            res_valid  <= 1'b0;
            res_data   <= '0;
        end else begin
            res_valid <= 1'b0;
            if (fin && conv_valid) begin
                pend_q     <= 1'b1;
                pend_raw_q <= conv_raw;
            end else if (ready && (pend_q || conv_valid)) begin
                res_valid <= 1'b1;
                res_data  <= clamped;
                pend_q    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/autocal_seq.sv
// Top of the autocalibration sequencer. It connects the step
// sequencer, the correction store and the conversion correction path.
// cal_req is an asynchronous clear; rst_n is a synchronous active-low reset.
module autocal_seq
    import acal_pkg::*;
#(
    parameter int N_BITS     = 9,
    parameter int MEAS_WAIT  = 32,
    parameter int CAL_CYCLES = 85530
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cal_req,
    output logic                            busy,
    output logic                            meas_start,
    output logic [$clog2(N_BITS+1)-1:0]     meas_sel,
    input  logic                            meas_valid,
    input  logic signed [ACAL_DW-1:0]       meas_value,
    input  logic                            conv_valid,
    input  logic [ACAL_DW-1:0]              conv_raw,
    output logic                            res_valid,
    output logic [ACAL_DW-1:0]              res_data
);
    localparam int N_ENTRIES = N_BITS + 1;
    localparam int IDX_W     = $clog2(N_ENTRIES);

    logic             fin;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    corr_t            wr_data;
    corr_t            entries [N_ENTRIES];

    acal_step_seq #(
        .N_ENTRIES  (N_ENTRIES),
        .MEAS_WAIT  (MEAS_WAIT),
        .CAL_CYCLES (CAL_CYCLES)
    ) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cal_req      (cal_req),
        .meas_valid   (meas_valid),
        .meas_value   (meas_value),
        .offset_entry (entries[0]),
        .busy         (busy),
        .fin          (fin),
        .meas_start   (meas_start),
        .meas_sel     (meas_sel),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_data      (wr_data)
    );

    acal_corr_ram #(
        .N_ENTRIES (N_ENTRIES)
    ) ram_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cal_req (cal_req),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .entries (entries)
    );

    acal_corr_apply #(
        .N_ENTRIES (N_ENTRIES)
    ) apply_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cal_req    (cal_req),
        .busy       (busy),
        .fin        (fin),
        .conv_valid (conv_valid),
        .conv_raw   (conv_raw),
        .entries    (entries),
        .res_valid  (res_valid),
        .res_data   (res_data)
    );
endmodule

// File: rtl/acal_chk.sv
// Protocol checker for autocal_seq, bound to every instance of the top.
module acal_chk #(
    parameter int N_BITS = 9,
    parameter int DW     = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cal_req,
    input logic                        busy,
    input logic                        meas_start,
    input logic [$clog2(N_BITS+1)-1:0] meas_sel,
    input logic                        conv_valid,
    input logic                        res_valid,
    input logic [DW-1:0]               res_data
);
    localparam int N_ENTRIES = N_BITS + 1;

    a_r1_request_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cal_req |-> (busy && !meas_start && !res_valid));

    a_r3_busy_stays_low: assert property (@(posedge clk) disable iff (!rst_n || cal_req)
        !busy |=> !busy);

    a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n || cal_req)
        meas_start |=> !meas_start);

    a_r4_sel_in_range: assert property (@(posedge clk) disable iff (!rst_n || cal_req)
        meas_start |-> (int'(meas_sel) < N_ENTRIES));

    a_r7_result_has_source: assert property (@(posedge clk) disable iff (!rst_n || cal_req)
        res_valid |-> ($past(conv_valid) || $past(conv_valid, 2)));

    a_r8_idle_while_busy: assert property (@(posedge clk) disable iff (!rst_n || cal_req)
        busy |=> !res_valid);

    a_r9_finish_stall: assert property (@(posedge clk) disable iff (!rst_n || cal_req)
        ($fell(busy) && conv_valid) |=> (!res_valid ##1 res_valid));

    a_r10_data_held: assert property (@(posedge clk) disable iff (!rst_n || cal_req)
        !res_valid |-> $stable(res_data));
endmodule

bind autocal_seq acal_chk #(
    .N_BITS (N_BITS),
    .DW     (acal_pkg::ACAL_DW)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cal_req    (cal_req),
    .busy       (busy),
    .meas_start (meas_start),
    .meas_sel   (meas_sel),
    .conv_valid (conv_valid),
    .res_valid  (res_valid),
    .res_data   (res_data)
);

// File: tb/autocal_seq_tb_top.sv
`timescale 1ns/1ps
module autocal_seq_tb_top;
    localparam int MW    = 32;
    localparam int CALC  = 85530;
    localparam int NSTEP = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cal_req = 1'b0;
    logic        busy;
    logic        meas_start;
    logic [3:0]  meas_sel;
    logic        meas_valid = 1'b0;
    logic signed [15:0] meas_value = '0;
    logic        conv_valid = 1'b0;
    logic [15:0] conv_raw = '0;
    logic        res_valid;
    logic [15:0] res_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Response schedule per step: first response offset/value, second offset/value (0 = none).
    localparam int D1 [NSTEP] = '{5, 1, 2, MW, 4, 6, 7, 8, MW+1, 0};
    localparam int V1 [NSTEP] = '{10, 110, 60, 35, -32768, 18, 14, 12, 500, 0};
    localparam int D2 [NSTEP] = '{0, 0, 3, 0, 0, 0, 0, 0, 0, 0};
    localparam int V2 [NSTEP] = '{0, 0, 999, 0, 0, 0, 0, 0, 0, 0};
    // Resulting entries: 10, 100, 50, 25, -32768, 8, 4, 2, -10, -10.

    // Stimulus {raw, expected corrected result}.
    localparam logic [31:0] VEC [12] = '{
        {16'h0005, 16'd0},     {16'h0100, 16'd256},   {16'h8000, 16'd32658},
        {16'h4000, 16'd16324}, {16'h2000, 16'd8157},  {16'h1000, 16'd36854},
        {16'hF000, 16'd65535}, {16'h0E00, 16'd3560},  {16'h0080, 16'd128},
        {16'hE0FF, 16'd57424}, {16'h000A, 16'd0},     {16'hEFFF, 16'd61260}
    };

    always #2.5 clk = ~clk;

    autocal_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cal_req    (cal_req),
        .busy       (busy),
        .meas_start (meas_start),
        .meas_sel   (meas_sel),
        .meas_valid (meas_valid),
        .meas_value (meas_value),
        .conv_valid (conv_valid),
        .conv_raw   (conv_raw),
        .res_valid  (res_valid),
        .res_data   (res_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Plays the measurement side for all ten steps; called at the falling edge where step 0 starts.
    task automatic responder();
        check(meas_start && meas_sel == 4'd0, "R4 first request sel", int'(meas_sel), 0);
        for (int s = 0; s < NSTEP; s++) begin
            for (int d = 1; d <= MW + 1; d++) begin
                @(negedge clk);
                if (d == D1[s]) begin
                    meas_valid = 1'b1;
                    meas_value = 16'(V1[s]);
                end else if (d == D2[s]) begin
                    meas_valid = 1'b1;
                    meas_value = 16'(V2[s]);
                end else begin
                    meas_valid = 1'b0;
                end
                if (d == 1)
                    check(!meas_start, "R4 request lasts one cycle", int'(meas_start), 0);
            end
            if (s < NSTEP - 1)
                check(meas_start && int'(meas_sel) == s + 1, "R4 step order and spacing",
                      meas_start ? int'(meas_sel) : -1, s + 1);
            else
                check(!meas_start, "R4 no request after last step", int'(meas_start), 0);
        end
        @(negedge clk);
        meas_valid = 1'b0;
    endtask

    // Counts edges from release; checks the busy fall and the finishing-cycle stall.
    task automatic edge_counter();
        for (int k = 1; k <= CALC + 2; k++) begin
            @(negedge clk);
            if (k == 100) begin
                conv_valid = 1'b1;
                conv_raw   = 16'h8000;
            end else if (k == 101) begin
                conv_valid = 1'b0;
                check(!res_valid, "R8 conversion ignored while busy", int'(res_valid), 0);
            end else if (k == CALC - 1) begin
                check(busy, "R3 busy high at edge 85529", int'(busy), 1);
                check(res_data == 16'd0, "R8 result unchanged while busy", int'(res_data), 0);
            end else if (k == CALC) begin
                check(!busy, "R3 busy low at edge 85530", int'(busy), 0);
                conv_valid = 1'b1;
                conv_raw   = 16'h8000;
            end else if (k == CALC + 1) begin
                conv_valid = 1'b0;
                check(!res_valid, "R9 no result after one cycle", int'(res_valid), 0);
            end else if (k == CALC + 2) begin
                check(res_valid && res_data == 16'd32658, "R9 result after two cycles",
                      int'(res_data), 32658);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Reset state.
        repeat (4) @(negedge clk);
        check(busy, "R2 busy in reset", int'(busy), 1);
        check(!meas_start, "R2 no request in reset", int'(meas_start), 0);
        check(!res_valid && res_data == 16'd0, "R2 result cleared in reset", int'(res_data), 0);

        // Release reset: routine starts immediately.
        rst_n = 1'b1;
        #1;
        check(meas_start && meas_sel == 4'd0, "R2 routine starts on release", int'(meas_sel), 0);

        // Conversion during calibration is ignored.
        repeat (10) @(negedge clk);
        conv_valid = 1'b1;
        conv_raw   = 16'h1234;
        @(negedge clk);
        conv_valid = 1'b0;
        check(!res_valid, "R8 ignored during first routine", int'(res_valid), 0);

        // Abort with a calibration request mid-routine.
        repeat (30) @(negedge clk);
        cal_req = 1'b1;
        #1;
        check(busy && !meas_start, "R1 request aborts and clears", int'(meas_start), 0);
        repeat (3) @(negedge clk);

        // Release the request and run the full routine.
        @(posedge clk);
        #1 cal_req = 1'b0;
        @(negedge clk);
        fork
            responder();
            edge_counter();
        join

        // Corrected results for the vector table.
        foreach (VEC[i]) begin
            @(negedge clk);
            conv_valid = 1'b1;
            conv_raw   = VEC[i][31:16];
            @(negedge clk);
            conv_valid = 1'b0;
            check(res_valid && res_data == VEC[i][15:0], "R5 R6 R7 corrected result",
                  int'(res_data), int'(VEC[i][15:0]));
            @(negedge clk);
            check(!res_valid && res_data == VEC[i][15:0], "R10 result held",
                  int'(res_data), int'(VEC[i][15:0]));
        end

        // A fresh request clears results without a clock.
        @(negedge clk);
        cal_req = 1'b1;
        #1;
        check(busy && !res_valid && res_data == 16'd0, "R1 clear of result on request",
              int'(res_data), 0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule